// File: doc/BRIEF.md
# Oversampled Serial Receiver with Break Handling

This block turns an asynchronous serial line into characters. It is clocked by the system clock and advances one step per pulse of a tick input that runs at sixteen times the bit rate. It finds the falling edge of a start bit and confirms it at mid-bit. It then collects between five and nine data bits, least significant first, and an optional parity bit. The first stop bit is checked last. Each finished character goes out on a one-cycle push interface, together with three tags that mark a parity fault, a framing fault or a line break. A FIFO downstream stores the pushed entries.

The block handles two line faults in a specific way. If the line is low at every sample of a frame, the block pushes one all-zero character tagged as a break. It then ignores the line until the line is seen high. If the stop bit is low but the frame is not a break, the block tags the character with a framing fault. It then takes that low stop sample as the start bit of the next character and goes straight into collecting data bits. The input line must already be synchronised to the system clock.

Top module: `serial_rx_deser`

## Requirements
- R1: After reset the receiver is idle and `pushValid` stays low until a full frame has been received.
- R2: A low sample on a tick while idle starts a frame. The start bit is sampled again 8 ticks later, and a high value there abandons the frame with no push. Each later bit is sampled 16 ticks after the previous sample.
- R3: In normal mode, `cfgDataLen` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. The bits are received LSB first and are presented right-aligned on `pushData`, with the unused upper bits at zero.
- R4: When `cfgParEn` is high and `cfgNineBit` is low, a parity bit follows the data bits. `cfgParOdd` high selects odd parity and low selects even. `pushParTag` is high exactly when the received parity bit does not match the parity computed from the data. With parity disabled, `pushParTag` is low.
- R5: When `cfgNineBit` is high, 9 data bits are received and no parity bit is expected, whatever `cfgParEn` holds. The first eight bits appear on `pushData`, and the ninth bit appears on `pushParTag`.
- R6: `pushValid` is a single-cycle pulse in the tick cycle that samples the first stop bit. The data and tags are valid in that same cycle.
- R7: A stop sample that is low, in a frame that is not a break, pushes the character with `pushFrameTag` high.
- R8: After a framing fault, the low stop sample counts as the start bit of the next character. The first data bit is sampled 16 ticks later, with no new falling edge needed.
- R9: A frame whose start, data, parity and stop samples are all low pushes exactly one entry: `pushData` zero, `pushBreakTag` high, and `pushFrameTag` and `pushParTag` low.
- R10: After a break push, no further frame starts and nothing is pushed until a tick samples the line high. The next falling edge after that starts a frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickIn | input | 1 | Oversampling strobe, 16 per bit period |
| rxIn | input | 1 | Serial line, idle high, already synchronised |
| cfgDataLen | input | 2 | Data length code, 0..3 gives 5..8 bits |
| cfgParEn | input | 1 | Parity bit present (normal mode) |
| cfgParOdd | input | 1 | 1 = odd parity, 0 = even parity |
| cfgNineBit | input | 1 | Nine-data-bit mode, parity off |
| pushValid | output | 1 | One-cycle push strobe |
| pushData | output | 8 | Received character, right-aligned |
| pushParTag | output | 1 | Parity fault, or ninth bit in nine-bit mode |
| pushFrameTag | output | 1 | Stop bit sampled low |
| pushBreakTag | output | 1 | Break character |

## Verification
The assertions check, on every cycle, several properties of the sequencing. The push strobe never lasts two cycles. A break push is always followed by the line-wait state and carries zero data with no other tag. A framing fault always re-enters data collection with the bit index at zero. The bit-phase counter moves only on ticks, and nine-bit mode never enters the parity phase. Other behaviours can only be shown by the bench, by driving real waveforms:
- the bit ordering and alignment for each data length;
- the parity values for odd and even parity, good and bad;
- glitch rejection at the start bit;
- correct decoding of the character that follows a resynchronised stop bit;
- the silence during a held-low line and the recovery after it.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_BRK   = 3'd5
  } rxState_t;

  // strobes from control to datapath, each one cycle wide on a sampling tick
  typedef struct packed {
    logic startOk;  // start bit confirmed low at mid-bit
    logic dataSmp;  // shift in one data bit
    logic parSmp;   // capture parity bit
    logic stopSmp;  // stop bit sample, push cycle
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int MAX_BITS = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic       rxIn,
  input  logic [1:0] cfgDataLen,
  input  logic       cfgParEn,
  input  logic       cfgNineBit,
  input  logic       isBreak,
  output rxStrobe_t  strb
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(MAX_BITS + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

  rxState_t         state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic [IDX_W-1:0] bitIdx, bitIdxN;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx = cfgNineBit ? IDX_W'(MAX_BITS - 1) : IDX_W'(4 + int'(cfgDataLen));

  always_comb begin
    stateN  = state;
    cntN    = cnt;
    bitIdxN = bitIdx;
    strb    = '0;
    unique case (state)
      S_IDLE: begin
        if (tickIn && !rxIn) begin
          stateN = S_START;
          cntN   = '0;
        end
      end
      S_START: begin
        if (tickIn) begin
          if (cnt == MID_CNT) begin
            cntN = '0;
            if (rxIn) begin
              stateN = S_IDLE;
            end else begin
              stateN       = S_DATA;
              bitIdxN      = '0;
              strb.startOk = 1'b1;
            end
          end else begin
            cntN = cnt + 1'b1;
          end
        end
      end
      S_DATA: begin
        if (tickIn) begin
          if (cnt == LAST_CNT) begin
            cntN         = '0;
            strb.dataSmp = 1'b1;
            if (bitIdx == lastIdx) begin
              stateN = (cfgParEn && !cfgNineBit) ? S_PAR : S_STOP;
            end else begin
              bitIdxN = bitIdx + 1'b1;
            end
          end else begin
            cntN = cnt + 1'b1;
          end
        end
      end
      S_PAR: begin
        if (tickIn) begin
          if (cnt == LAST_CNT) begin
            cntN        = '0;
            strb.parSmp = 1'b1;
            stateN      = S_STOP;
          end else begin
            cntN = cnt + 1'b1;
          end
        end
      end
      S_STOP: begin
        if (tickIn) begin
          if (cnt == LAST_CNT) begin
            cntN         = '0;
            strb.stopSmp = 1'b1;
            bitIdxN      = '0;
            if (rxIn)         stateN = S_IDLE;
            else if (isBreak) stateN = S_BRK;
            else              stateN = S_DATA;  // low stop taken as next start
          end else begin
            cntN = cnt + 1'b1;
          end
        end
      end
      S_BRK: begin
        if (tickIn && rxIn) stateN = S_IDLE;
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateN;
      cnt    <= cntN;
      bitIdx <= bitIdxN;
    end
  end

  // R6: the push strobe never lasts two cycles
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strb.stopSmp |=> !strb.stopSmp);

  // R10: a break push always parks the receiver until the line is high
  a_r10_break_wait: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stopSmp && isBreak && !rxIn) |=> (state == S_BRK));

  // R8: a framing fault re-enters data collection at bit zero
  a_r8_resync: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stopSmp && !rxIn && !isBreak) |=> (state == S_DATA && bitIdx == '0 && cnt == '0));

  // R2: the bit-phase counter moves only on ticks
  a_r2_cnt_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn |=> $stable(cnt));

  // R5: nine-bit mode never enters the parity phase
  a_r5_no_parity_phase: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && cfgNineBit) |=> (state != S_PAR));
endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
#(
  parameter int MAX_BITS = 9,
  parameter int OUT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic [1:0]       cfgDataLen,
  input  logic             cfgParEn,
  input  logic             cfgParOdd,
  input  logic             cfgNineBit,
  input  rxStrobe_t        strb,
  output logic             isBreak,
  output logic             pushValid,
  output logic [OUT_W-1:0] pushData,
  output logic             pushParTag,
  output logic             pushFrameTag,
  output logic             pushBreakTag
);
  logic [MAX_BITS-1:0] shReg;
  logic [MAX_BITS-1:0] aligned;
  logic                parBit;
  logic                allLow;
  logic                parErr;

  // bits enter at the top and move down; align by the configured length
  always_comb begin
    if (cfgNineBit) begin
      aligned = shReg;
    end else begin
      unique case (cfgDataLen)
        2'd0:    aligned = shReg >> (MAX_BITS - 5);
        2'd1:    aligned = shReg >> (MAX_BITS - 6);
        2'd2:    aligned = shReg >> (MAX_BITS - 7);
        default: aligned = shReg >> (MAX_BITS - 8);
      endcase
    end
  end

  assign isBreak = allLow && !rxIn;
  assign parErr  = cfgParEn && !cfgNineBit && ((^aligned[OUT_W-1:0]) ^ parBit ^ cfgParOdd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      parBit <= 1'b0;
      allLow <= 1'b0;
    end else if (strb.startOk || strb.stopSmp) begin
      shReg  <= '0;
      parBit <= 1'b0;
      allLow <= 1'b1;
    end else if (strb.dataSmp) begin
      shReg  <= {rxIn, shReg[MAX_BITS-1:1]};
      allLow <= allLow && !rxIn;
    end else if (strb.parSmp) begin
      parBit <= rxIn;
      allLow <= allLow && !rxIn;
    end
  end

  assign pushValid    = strb.stopSmp;
  assign pushData     = isBreak ? '0 : aligned[OUT_W-1:0];
  assign pushBreakTag = strb.stopSmp && isBreak;
  assign pushFrameTag = strb.stopSmp && !rxIn && !isBreak;
  assign pushParTag   = strb.stopSmp && !isBreak && (cfgNineBit ? aligned[MAX_BITS-1] : parErr);

  // R9: a break frame has collected only zero bits
  a_r9_break_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stopSmp && isBreak) |-> (shReg == '0 && parBit == 1'b0));

  // R9: break entries carry no other tag
  a_r9_break_alone: assert property (@(posedge clk) disable iff (!rstN)
    pushBreakTag |-> (!pushFrameTag && !pushParTag && pushValid));
endmodule

// File: rtl/serial_rx_deser.sv
module serial_rx_deser
  import serial_rx_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int MAX_BITS = 9,
  parameter int OUT_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             rxIn,
  input  logic [1:0]       cfgDataLen,
  input  logic             cfgParEn,
  input  logic             cfgParOdd,
  input  logic             cfgNineBit,
  output logic             pushValid,
  output logic [OUT_W-1:0] pushData,
  output logic             pushParTag,
  output logic             pushFrameTag,
  output logic             pushBreakTag
);
  rxStrobe_t strb;
  logic      isBreak;

  serial_rx_ctrl #(.OSR(OSR), .MAX_BITS(MAX_BITS)) ctrl_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .rxIn(rxIn),
    .cfgDataLen(cfgDataLen), .cfgParEn(cfgParEn), .cfgNineBit(cfgNineBit),
    .isBreak(isBreak), .strb(strb)
  );

  serial_rx_dpath #(.MAX_BITS(MAX_BITS), .OUT_W(OUT_W)) dpath_i (
    .clk(clk), .rstN(rstN), .rxIn(rxIn),
    .cfgDataLen(cfgDataLen), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .cfgNineBit(cfgNineBit), .strb(strb), .isBreak(isBreak),
    .pushValid(pushValid), .pushData(pushData), .pushParTag(pushParTag),
    .pushFrameTag(pushFrameTag), .pushBreakTag(pushBreakTag)
  );

  // R6: pushes land only on sampling ticks
  a_r6_push_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> tickIn);
endmodule

// File: tb/serial_rx_deser_tb_top.sv
module serial_rx_deser_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn;
  logic       rxIn = 1'b1;
  logic [1:0] cfgDataLen = 2'd3;
  logic       cfgParEn = 1'b0;
  logic       cfgParOdd = 1'b0;
  logic       cfgNineBit = 1'b0;
  logic       pushValid;
  logic [7:0] pushData;
  logic       pushParTag, pushFrameTag, pushBreakTag;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  int tickCnt = 0;
  always_ff @(posedge clk) tickCnt <= (tickCnt == TICK_DIV - 1) ? 0 : tickCnt + 1;
  assign tickIn = (tickCnt == 0) && rstN;

  serial_rx_deser dut_i (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .rxIn(rxIn),
    .cfgDataLen(cfgDataLen), .cfgParEn(cfgParEn), .cfgParOdd(cfgParOdd),
    .cfgNineBit(cfgNineBit), .pushValid(pushValid), .pushData(pushData),
    .pushParTag(pushParTag), .pushFrameTag(pushFrameTag), .pushBreakTag(pushBreakTag)
  );

  // push monitor, sampled at the falling edge
  int         nPush = 0;
  logic [7:0] capData [0:3];
  logic [2:0] capTags [0:3];  // {break, frame, parity}
  bit         prevValid = 1'b0;
  int         longPulses = 0;
  always @(negedge clk) begin
    if (pushValid) begin
      if (nPush < 4) begin
        capData[nPush] = pushData;
        capTags[nPush] = {pushBreakTag, pushFrameTag, pushParTag};
      end
      nPush++;
      if (prevValid) longPulses++;
    end
    prevValid = pushValid;
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drvBit(input logic b);
    @(negedge clk);
    rxIn = b;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  // sends start, nBits data LSB first, optional parity, stop; then idles
  task automatic sendFrame(input logic [8:0] d, input int nBits, input bit hasPar,
                           input logic parVal, input logic stopVal);
    drvBit(1'b0);
    for (int i = 0; i < nBits; i++) drvBit(d[i]);
    if (hasPar) drvBit(parVal);
    drvBit(stopVal);
  endtask

  task automatic idleBits(input int n);
    @(negedge clk);
    rxIn = 1'b1;
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic expectOne(input string req, input logic [7:0] d, input logic [2:0] tags);
    check(req, nPush == 1, nPush, 1);
    if (nPush >= 1) begin
      check(req, capData[0] == d, capData[0], d);
      check(req, capTags[0] == tags, capTags[0], tags);
    end
  endtask

  task automatic testReset();
    repeat (40) @(negedge clk);
    check("R1", nPush == 0 && pushValid == 1'b0, nPush, 0);
  endtask

  task automatic testLengths();
    logic [7:0] pat [0:3];
    pat[0] = 8'h15; pat[1] = 8'h2E; pat[2] = 8'h4B; pat[3] = 8'hA7;
    cfgParEn = 1'b0; cfgNineBit = 1'b0;
    for (int l = 0; l < 4; l++) begin
      cfgDataLen = 2'(l);
      nPush = 0;
      sendFrame({1'b0, pat[l]}, 5 + l, 1'b0, 1'b0, 1'b1);
      idleBits(2);
      // R3: right-aligned, upper bits zero
      expectOne("R3", pat[l] & 8'((1 << (5 + l)) - 1), 3'b000);
    end
  endtask

  task automatic testParity();
    logic [7:0] d = 8'h6D;  // five ones
    cfgDataLen = 2'd3; cfgParEn = 1'b1; cfgNineBit = 1'b0;
    for (int m = 0; m < 4; m++) begin
      logic good;
      cfgParOdd = m[0];
      // even parity bit makes the total even; odd makes it odd
      good = (^d) ^ cfgParOdd;
      nPush = 0;
      sendFrame({1'b0, d}, 8, 1'b1, m[1] ? ~good : good, 1'b1);
      idleBits(2);
      expectOne("R4", d, {2'b00, m[1]});
    end
    cfgParEn = 1'b0; cfgParOdd = 1'b0;
  endtask

  task automatic testNine();
    cfgNineBit = 1'b1; cfgParEn = 1'b1;
    nPush = 0;
    sendFrame(9'h1C3, 9, 1'b0, 1'b0, 1'b1);
    idleBits(2);
    expectOne("R5", 8'hC3, 3'b001);
    nPush = 0;
    sendFrame(9'h05A, 9, 1'b0, 1'b0, 1'b1);
    idleBits(2);
    expectOne("R5", 8'h5A, 3'b000);
    cfgNineBit = 1'b0; cfgParEn = 1'b0;
  endtask

  task automatic testGlitch();
    cfgDataLen = 2'd3;
    nPush = 0;
    @(negedge clk); rxIn = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxIn = 1'b1;
    idleBits(12);
    check("R2", nPush == 0, nPush, 0);
    sendFrame(9'h03C, 8, 1'b0, 1'b0, 1'b1);
    idleBits(2);
    expectOne("R2", 8'h3C, 3'b000);
  endtask

  task automatic testFrameResync();
    cfgDataLen = 2'd3;
    nPush = 0;
    sendFrame(9'h0B1, 8, 1'b0, 1'b0, 1'b0);  // stop low
    for (int i = 0; i < 8; i++) drvBit(1'(8'h69 >> i));
    drvBit(1'b1);
    idleBits(2);
    check("R8", nPush == 2, nPush, 2);
    check("R7", capData[0] == 8'hB1 && capTags[0] == 3'b010, {capTags[0], capData[0]}, {3'b010, 8'hB1});
    check("R8", capData[1] == 8'h69 && capTags[1] == 3'b000, {capTags[1], capData[1]}, {3'b000, 8'h69});
  endtask

  task automatic testBreak();
    cfgDataLen = 2'd3; cfgParEn = 1'b1; cfgParOdd = 1'b1;
    nPush = 0;
    @(negedge clk); rxIn = 1'b0;
    repeat (20 * BIT_CLKS) @(negedge clk);
    // R9: one break entry; R10: nothing more while the line stays low
    check("R9", nPush == 1, nPush, 1);
    check("R9", capData[0] == 8'h00 && capTags[0] == 3'b100, {capTags[0], capData[0]}, {3'b100, 8'h00});
    check("R10", nPush == 1, nPush, 1);
    idleBits(2);
    check("R10", nPush == 1, nPush, 1);
    cfgParEn = 1'b0; cfgParOdd = 1'b0;
    nPush = 0;
    sendFrame(9'h0E4, 8, 1'b0, 1'b0, 1'b1);
    idleBits(2);
    expectOne("R10", 8'hE4, 3'b000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testLengths();
    testParity();
    testNine();
    testGlitch();
    testFrameResync();
    testBreak();
    check("R6", longPulses == 0, longPulses, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule